// File: doc/BRIEF.md
# Flash Erase-Verify Sequencer

This controller runs the erase and erase-verify loop for a flash array split into two banks. It receives a start command and a mask of blocks to erase. It then takes the selected blocks one at a time, lowest index first. For each block it steps that block's bank through its mode bits: write enable, erase setup, erase pulse, and verify. Every step waits a minimum time, and every delay is a cycle count set by a parameter.

In verify mode the sequencer writes a dummy word of all ones to each word address of the block. It then reads the same address back. A word that does not read all ones sends the block back through a new erase pulse. The number of erase pulses per block is capped. When every selected block has been erased, write enable is dropped and `done_o` rises after a final wait. If the cap is hit, `fail_o` rises. Both status bits hold until the next start.

Top module: `flash_erase_seq`

## Requirements
- R1: The bank whose address bit 18 is 0 is driven on index 0 of `swe_o`, `esu_o`, `ers_o` and `ev_o`; a bank with bit 18 set is driven on index 1. Only the current block's bank is driven.
- R2: Erase entry raises the setup bit first. At least T_SETUP+1 cycles later it raises the erase bit, which stays high for exactly ERASE_T+1 cycles. The verify bit is never high together with setup or erase.
- R3: Erase exit clears the erase bit first. The setup bit clears no sooner than ALPHA+1 cycles after that.
- R4: At least BETA+1 cycles after the setup bit clears, `wdt_clr_o` pulses for one cycle. The verify bit rises in the next cycle.
- R5: Each verify read (`rd_stb_o`) is preceded by a one-cycle dummy write (`wr_stb_o`) of 16'hFFFF to the same address. The first dummy write comes at least GAMMA+1 cycles after the verify bit rises. Each read comes at least EPS+1 cycles after its write.
- R6: Verify walks word addresses from the block's base to its end address, inclusive, in steps of 2. A word that reads 16'hFFFF moves the walk to the next address.
- R7: A word that reads anything other than 16'hFFFF ends verify and starts a new erase pulse, after which verify restarts at the base address. If N_MAX erase pulses have already been given to the block, the sequencer instead clears all control bits and raises `fail_o` with `done_o` low.
- R8: After a block's last word passes, the verify bit clears. At least ETA+1 cycles pass before write enable drops or the next block starts. Blocks are erased in increasing index order.
- R9: After the last block, write enable clears, and `done_o` rises at least THETA+1 cycles later. `done_o` and `fail_o` are never high together.
- R10: The pulse limit counts separately for each block, and at most one block is selected at a time.
- R11: A start with an empty mask gives no erase pulse and no verify read, and ends with `done_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command, one cycle |
| blk_mask_i | input | NBLK | Blocks to erase |
| rd_data_i | input | 16 | Array read data for `addr_o` |
| swe_o | output | 2 | Write enable per bank |
| esu_o | output | 2 | Erase setup per bank |
| ers_o | output | 2 | Erase pulse per bank |
| ev_o | output | 2 | Erase-verify per bank |
| addr_o | output | AW | Array byte address |
| wr_stb_o | output | 1 | Dummy-write strobe |
| wr_data_o | output | 16 | Dummy-write data |
| rd_stb_o | output | 1 | Verify-read strobe |
| wdt_clr_o | output | 1 | Watchdog-clear pulse |
| done_o | output | 1 | All selected blocks erased |
| fail_o | output | 1 | Pulse limit exceeded |

## Verification
The bench builds the sequencer with four blocks of four words each, two blocks in each bank, and with delays of two to six cycles. At those sizes every gap between mode-bit edges can be measured against its minimum within a few hundred cycles. N_MAX is 3, so the bench array model, which clears a word once a set number of erase pulses has occurred, reaches a pass on the last allowed pulse, a fail one pulse past it, and a mid-block word that forces a restart from the base address. Because the pulse limit is small, a second block needing more pulses in total than the limit can only pass if the count restarts for each block.

// File: rtl/fev_pkg.sv
package fev_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PICK, S_ESU_ON, S_ERS_ON, S_ERS_OFF, S_ESU_OFF, S_WDT,
    S_EV_ON, S_DWR, S_RDW, S_RD, S_EV_OFF, S_SWE_OFF, S_DONE, S_FAIL
  } fev_state_e;
endpackage

// File: rtl/fev_wait_timer.sv
module fev_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) cnt_d = load_val_i;
    else if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/fev_pick.sv
module fev_pick #(
  parameter int NBLK = 4,
  parameter int IW   = 2
) (
  input  logic [NBLK-1:0] mask_i,
  output logic [IW-1:0]   idx_o,
  output logic            any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NBLK - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |mask_i;
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fev_pkg::*;
#(
  parameter int NBLK     = 4,
  parameter int AW       = 19,
  parameter int BANK_BIT = 18,
  parameter logic [NBLK*AW-1:0] BLK_BASE = {19'h40010, 19'h40000, 19'h00010, 19'h00000},
  parameter logic [NBLK*AW-1:0] BLK_END  = {19'h40016, 19'h40006, 19'h00016, 19'h00006},
  parameter int T_SETUP  = 200,
  parameter int ERASE_T  = 2000,
  parameter int ALPHA    = 100,
  parameter int BETA     = 200,
  parameter int GAMMA    = 400,
  parameter int EPS      = 40,
  parameter int ETA      = 400,
  parameter int THETA    = 2000,
  parameter int N_MAX    = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [NBLK-1:0] blk_mask_i,
  input  logic [15:0]     rd_data_i,
  output logic [1:0]      swe_o,
  output logic [1:0]      esu_o,
  output logic [1:0]      ers_o,
  output logic [1:0]      ev_o,
  output logic [AW-1:0]   addr_o,
  output logic            wr_stb_o,
  output logic [15:0]     wr_data_o,
  output logic            rd_stb_o,
  output logic            wdt_clr_o,
  output logic            done_o,
  output logic            fail_o
);
  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXD = max2(max2(max2(T_SETUP, ERASE_T), max2(ALPHA, BETA)),
                             max2(max2(GAMMA, EPS), max2(ETA, THETA)));
  localparam int CW = (MAXD < 1) ? 1 : $clog2(MAXD + 1);
  localparam int IW = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam int RW = $clog2(N_MAX + 1);

  fev_state_e      state_q, state_d;
  logic [NBLK-1:0] pend_q, pend_d, sel_q, sel_d;
  logic [IW-1:0]   cur_q, cur_d, pick_idx;
  logic            bank_q, bank_d, pick_any;
  logic [AW-1:0]   addr_q, addr_d, base_cur, end_cur;
  logic [RW-1:0]   loops_q, loops_d;
  logic [1:0]      swe_q, swe_d, bank_vec;
  logic            tmr_load, tmr_exp;
  logic [CW-1:0]   tmr_val;

  fev_pick #(.NBLK(NBLK), .IW(IW)) pick_i (
    .mask_i(pend_q), .idx_o(pick_idx), .any_o(pick_any)
  );

  fev_wait_timer #(.CW(CW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .expired_o(tmr_exp)
  );

  assign base_cur = BLK_BASE[cur_q*AW +: AW];
  assign end_cur  = BLK_END[cur_q*AW +: AW];

  // next-state logic
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    sel_d   = sel_q;
    cur_d   = cur_q;
    bank_d  = bank_q;
    addr_d  = addr_q;
    loops_d = loops_q;
    swe_d   = swe_q;
    unique case (state_q)
      S_IDLE, S_DONE, S_FAIL: begin
        if (start_i) begin
          pend_d  = blk_mask_i;
          state_d = S_PICK;
        end
      end
      S_PICK: begin
        if (!pick_any) begin
          swe_d   = 2'b00;
          state_d = S_SWE_OFF;
        end else begin
          sel_d   = NBLK'(1) << pick_idx;
          cur_d   = pick_idx;
          bank_d  = BLK_BASE[pick_idx*AW + BANK_BIT];
          swe_d   = BLK_BASE[pick_idx*AW + BANK_BIT] ? 2'b10 : 2'b01;
          loops_d = '0;
          state_d = S_ESU_ON;
        end
      end
      S_ESU_ON: if (tmr_exp) begin
        loops_d = loops_q + RW'(1);
        state_d = S_ERS_ON;
      end
      S_ERS_ON:  if (tmr_exp) state_d = S_ERS_OFF;
      S_ERS_OFF: if (tmr_exp) state_d = S_ESU_OFF;
      S_ESU_OFF: if (tmr_exp) state_d = S_WDT;
      S_WDT: begin
        addr_d  = base_cur;
        state_d = S_EV_ON;
      end
      S_EV_ON: if (tmr_exp) state_d = S_DWR;
      S_DWR:   state_d = S_RDW;
      S_RDW:   if (tmr_exp) state_d = S_RD;
      S_RD: begin
        if (rd_data_i == 16'hFFFF) begin
          if (addr_q == end_cur) state_d = S_EV_OFF;
          else begin
            addr_d  = addr_q + AW'(2);
            state_d = S_DWR;
          end
        end else if (loops_q >= RW'(N_MAX)) begin
          swe_d   = 2'b00;
          sel_d   = '0;
          state_d = S_FAIL;
        end else begin
          state_d = S_ESU_ON;
        end
      end
      S_EV_OFF: if (tmr_exp) begin
        pend_d  = pend_q & ~sel_q;
        sel_d   = '0;
        state_d = S_PICK;
      end
      S_SWE_OFF: if (tmr_exp) state_d = S_DONE;
      default: state_d = S_IDLE;
    endcase
  end

  // minimum-delay selection for the state being entered
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      S_ESU_ON:  tmr_val = CW'(T_SETUP);
      S_ERS_ON:  tmr_val = CW'(ERASE_T);
      S_ERS_OFF: tmr_val = CW'(ALPHA);
      S_ESU_OFF: tmr_val = CW'(BETA);
      S_EV_ON:   tmr_val = CW'(GAMMA);
      S_RDW:     tmr_val = CW'(EPS);
      S_EV_OFF:  tmr_val = CW'(ETA);
      S_SWE_OFF: tmr_val = CW'(THETA);
      default:   tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pend_q  <= '0;
      sel_q   <= '0;
      cur_q   <= '0;
      bank_q  <= 1'b0;
      addr_q  <= '0;
      loops_q <= '0;
      swe_q   <= 2'b00;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      sel_q   <= sel_d;
      cur_q   <= cur_d;
      bank_q  <= bank_d;
      addr_q  <= addr_d;
      loops_q <= loops_d;
      swe_q   <= swe_d;
    end
  end

  // Moore output decode
  assign bank_vec  = bank_q ? 2'b10 : 2'b01;
  assign swe_o     = swe_q;
  assign esu_o     = (state_q inside {S_ESU_ON, S_ERS_ON, S_ERS_OFF}) ? bank_vec : 2'b00;
  assign ers_o     = (state_q == S_ERS_ON) ? bank_vec : 2'b00;
  assign ev_o      = (state_q inside {S_EV_ON, S_DWR, S_RDW, S_RD}) ? bank_vec : 2'b00;
  assign addr_o    = addr_q;
  assign wr_stb_o  = (state_q == S_DWR);
  assign wr_data_o = 16'hFFFF;
  assign rd_stb_o  = (state_q == S_RD);
  assign wdt_clr_o = (state_q == S_WDT);
  assign done_o    = (state_q == S_DONE);
  assign fail_o    = (state_q == S_FAIL);
endmodule

// File: rtl/fev_checker.sv
module fev_checker #(
  parameter int NBLK = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      swe_o,
  input logic [1:0]      esu_o,
  input logic [1:0]      ers_o,
  input logic [1:0]      ev_o,
  input logic            wr_stb_o,
  input logic [15:0]     wr_data_o,
  input logic            wdt_clr_o,
  input logic            done_o,
  input logic            fail_o,
  input logic [NBLK-1:0] sel_q
);
  p_bank_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(swe_o) && (((esu_o | ers_o | ev_o) & ~swe_o) == 2'b00));

  p_erase_in_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ers_o) |-> ((ers_o & ~esu_o) == 2'b00));

  p_verify_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !((|ev_o) && ((|esu_o) || (|ers_o))));

  p_setup_outlasts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|ers_o) |-> (|esu_o));

  p_wdt_then_ev_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|ev_o) |-> $past(wdt_clr_o));

  p_wdt_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr_o |=> !wdt_clr_o);

  p_dummy_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> ((wr_data_o == 16'hFFFF) && (|ev_o)));

  p_status_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q));
endmodule

bind flash_erase_seq fev_checker #(.NBLK(NBLK)) chk_i (
  .clk(clk), .rst_n(rst_n), .swe_o(swe_o), .esu_o(esu_o), .ers_o(ers_o),
  .ev_o(ev_o), .wr_stb_o(wr_stb_o), .wr_data_o(wr_data_o),
  .wdt_clr_o(wdt_clr_o), .done_o(done_o), .fail_o(fail_o), .sel_q(sel_q)
);

// File: tb/flash_erase_seq_tb_top.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;
  localparam int NBLK = 4, AW = 19;
  localparam int T_SETUP = 2, ERASE_T = 5, ALPHA = 3, BETA = 4;
  localparam int GAMMA = 2, EPS = 3, ETA = 2, THETA = 6, N_MAX = 3;

  logic clk, rst_n, start;
  logic [NBLK-1:0] mask;
  logic [15:0] rd_data;
  logic [1:0] swe, esu, ers, ev;
  logic [AW-1:0] addr;
  logic wr_stb, rd_stb, wdt_clr, done, fail;
  logic [15:0] wr_data;

  int total = 0, bad = 0;
  int thr_blk [4];
  logic [AW-1:0] stub_addr;
  int stub_thr;

  flash_erase_seq #(
    .NBLK(NBLK), .AW(AW), .T_SETUP(T_SETUP), .ERASE_T(ERASE_T), .ALPHA(ALPHA),
    .BETA(BETA), .GAMMA(GAMMA), .EPS(EPS), .ETA(ETA), .THETA(THETA), .N_MAX(N_MAX)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .blk_mask_i(mask),
    .rd_data_i(rd_data), .swe_o(swe), .esu_o(esu), .ers_o(ers), .ev_o(ev),
    .addr_o(addr), .wr_stb_o(wr_stb), .wr_data_o(wr_data), .rd_stb_o(rd_stb),
    .wdt_clr_o(wdt_clr), .done_o(done), .fail_o(fail)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // array model: a word reads erased once enough erase pulses occurred
  int cp;
  function automatic int thr_of(logic [AW-1:0] a);
    if (a == stub_addr) return stub_thr;
    return thr_blk[{a[18], a[4]}];
  endfunction
  always_comb rd_data = (cp >= thr_of(addr)) ? 16'hFFFF : 16'h7FFF;

  // monitor
  int cyc = 0, n_ers, n_rd;
  int ers_bank [0:63];
  logic [AW-1:0] rd_log [0:63];
  int t_esu_r, t_ers_r, t_ers_f, t_esu_f, t_wdt, t_ev_r, t_ev_f, t_wr, t_swe_f;
  int v_setup, v_width, v_alpha, v_beta, v_wdt_ev, v_gamma, v_eps, v_ad, v_data, v_eta, v_theta;
  bit first_wr, had_ev_f;
  logic p_esu, p_ers, p_ev, p_swe, p_done;
  logic [AW-1:0] last_wa;

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (start) begin
      cp = 0; n_ers = 0; n_rd = 0; had_ev_f = 0; first_wr = 0;
      v_setup = 0; v_width = 0; v_alpha = 0; v_beta = 0; v_wdt_ev = 0;
      v_gamma = 0; v_eps = 0; v_ad = 0; v_data = 0; v_eta = 0; v_theta = 0;
    end else if (rst_n) begin
      if ((|esu) && !p_esu) t_esu_r = cyc;
      if ((|ers) && !p_ers) begin
        cp++;
        ers_bank[n_ers[5:0]] = ers[1] ? 1 : 0;
        n_ers++;
        if (cyc - t_esu_r < T_SETUP + 1) v_setup++;
        t_ers_r = cyc;
      end
      if (!(|ers) && p_ers) begin
        if (cyc - t_ers_r != ERASE_T + 1) v_width++;
        t_ers_f = cyc;
      end
      if (!(|esu) && p_esu) begin
        if (cyc - t_ers_f < ALPHA + 1) v_alpha++;
        t_esu_f = cyc;
      end
      if (wdt_clr) begin
        if (cyc - t_esu_f < BETA + 1) v_beta++;
        t_wdt = cyc;
      end
      if ((|ev) && !p_ev) begin
        if (cyc - t_wdt != 1) v_wdt_ev++;
        t_ev_r = cyc; first_wr = 1;
      end
      if (wr_stb) begin
        if (first_wr && (cyc - t_ev_r < GAMMA + 1)) v_gamma++;
        first_wr = 0;
        if (wr_data != 16'hFFFF) v_data++;
        last_wa = addr; t_wr = cyc;
      end
      if (rd_stb) begin
        if (cyc - t_wr < EPS + 1) v_eps++;
        if (addr != last_wa) v_ad++;
        rd_log[n_rd[5:0]] = addr;
        n_rd++;
      end
      if (!(|ev) && p_ev) begin t_ev_f = cyc; had_ev_f = 1; end
      if (!(|swe) && p_swe) t_swe_f = cyc;
      if (done && !p_done) begin
        if (had_ev_f && (t_swe_f - t_ev_f < ETA + 1)) v_eta++;
        if (had_ev_f && (cyc - t_swe_f < THETA + 1)) v_theta++;
      end
    end
    p_esu = |esu; p_ers = |ers; p_ev = |ev; p_swe = |swe; p_done = done;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [NBLK-1:0] m);
    @(posedge clk); #1;
    mask = m; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done || fail) break;
    end
  endtask

  task automatic chk_seq(input string req, input logic [AW-1:0] exp_a [], input int n);
    int mism = 0;
    chk(n_rd == n, req, n_rd, n);
    for (int i = 0; i < n && i < n_rd; i++) if (rd_log[i] != exp_a[i]) mism++;
    chk(mism == 0, req, mism, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk({swe, esu, ers, ev} == 8'h00, "R1 reset bits", {swe, esu, ers, ev}, 0);
    chk({wr_stb, rd_stb, wdt_clr, done, fail} == 5'b0, "R9 reset status",
        {wr_stb, rd_stb, wdt_clr, done, fail}, 0);
  endtask

  task automatic t_single;
    logic [AW-1:0] e [] = '{19'h0, 19'h2, 19'h4, 19'h6};
    thr_blk = '{1, 1, 1, 1}; stub_addr = '1; stub_thr = 0;
    run(4'b0001);
    chk(done && !fail, "R9 done single", {done, fail}, 2);
    chk(n_ers == 1 && ers_bank[0] == 0, "R1 bank0 pulse", n_ers, 1);
    chk(v_setup == 0 && v_width == 0, "R2 setup/width", v_setup + v_width, 0);
    chk(v_alpha == 0, "R3 alpha gap", v_alpha, 0);
    chk(v_beta == 0 && v_wdt_ev == 0, "R4 wdt order", v_beta + v_wdt_ev, 0);
    chk(v_gamma + v_eps + v_ad + v_data == 0, "R5 dummy write", v_gamma + v_eps + v_ad + v_data, 0);
    chk_seq("R6 walk", e, 4);
    chk(v_eta == 0, "R8 eta gap", v_eta, 0);
    chk(v_theta == 0, "R9 theta gap", v_theta, 0);
  endtask

  task automatic t_two_bank;
    thr_blk = '{1, 1, 1, 3}; stub_addr = '1;
    run(4'b1010);
    chk(done && !fail, "R8 done two banks", {done, fail}, 2);
    chk(n_ers == 3, "R7 pulses", n_ers, 3);
    chk(ers_bank[0] == 0 && ers_bank[1] == 1 && ers_bank[2] == 1, "R1 bank order",
        ers_bank[0] * 4 + ers_bank[1] * 2 + ers_bank[2], 3);
    chk(n_rd == 9 && rd_log[0] == 19'h10 && rd_log[4] == 19'h40010, "R8 block order",
        n_rd, 9);
    chk(v_width + v_alpha + v_beta + v_gamma + v_eps == 0, "R2 gaps two banks",
        v_width + v_alpha + v_beta + v_gamma + v_eps, 0);
  endtask

  task automatic t_stub;
    logic [AW-1:0] e [] = '{19'h40000, 19'h40002, 19'h40004, 19'h40000,
                             19'h40002, 19'h40004, 19'h40006};
    thr_blk = '{1, 1, 1, 1}; stub_addr = 19'h40004; stub_thr = 2;
    run(4'b0100);
    chk(done && n_ers == 2, "R7 mid-block retry", n_ers, 2);
    chk_seq("R7 restart at base", e, 7);
  endtask

  task automatic t_fail;
    thr_blk = '{10, 1, 1, 1}; stub_addr = '1;
    run(4'b0001);
    chk(fail && !done, "R7 fail", {done, fail}, 1);
    chk(n_ers == N_MAX, "R7 pulse cap", n_ers, N_MAX);
    chk({swe, esu, ers, ev} == 8'h00, "R7 bits cleared", {swe, esu, ers, ev}, 0);
  endtask

  task automatic t_retry_reset;
    thr_blk = '{3, 5, 1, 1}; stub_addr = '1;
    run(4'b0011);
    chk(done && !fail, "R10 per-block limit", {done, fail}, 2);
    chk(n_ers == 5, "R10 pulses", n_ers, 5);
  endtask

  task automatic t_empty;
    run(4'b0000);
    chk(done && !fail, "R11 empty done", {done, fail}, 2);
    chk(n_ers == 0 && n_rd == 0, "R11 no activity", n_ers + n_rd, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mask = '0;
    thr_blk = '{1, 1, 1, 1}; stub_addr = '1; stub_thr = 0; cp = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_single();
    t_two_bank();
    t_stub();
    t_fail();
    t_retry_reset();
    t_empty();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule